// File: doc/BRIEF.md
# Resolver Monitor and Loss-of-Signal Fault Latch

This block sits after the demodulator of a resolver-to-digital tracking loop. Each time a new demodulated sample pair arrives, it forms a monitor value from the sine and cosine resolver samples, weighted by the sine and cosine of the angle the loop is currently tracking. When both resolver amplitudes are healthy and the loop is locked, this weighted sum stays at the resolver amplitude at every shaft angle. A weak, missing or mismatched winding pulls it down or makes it swing.

When a monitor value falls below a fixed minimum, the block declares loss of signal and drives both of its active-low fault outputs low. The degradation output and the tracking-loss output also accept set requests from fault detectors elsewhere on the chip. A two-bit fault class records the most severe fault latched so far: loss of signal, then degradation, then tracking loss. Every latch holds until software or a host raises an asynchronous clear strobe. That strobe is resynchronised, and only its rising edge releases the latches.

Top module: `rsv_mon_top`

## Requirements
- R1: With `smp_valid` high at a clock edge, `mon` takes the value (sin_in·sin_phi + cos_in·cos_phi) arithmetically shifted right by 15 and saturated to the signed 16-bit range, one cycle later. `mon_valid` is high in exactly that cycle.
- R2: With both input amplitudes equal to A and the tracked angle equal to the shaft angle, `mon` stays within 3 LSB of A at any angle. With unequal amplitudes, `mon` follows the cosine amplitude at 0° and the sine amplitude at 90°.
- R3: A `mon_valid` cycle with signed `mon` below THRESH (default 3277) drives `dos_n` and `lot_n` both low and sets `fault_kind` to 3 (loss of signal) at the next edge.
- R4: Once low, `dos_n` and `lot_n` stay low when later monitor values are healthy, and both stay low until a clear.
- R5: `clr_async` passes through a two-flop synchroniser. The outputs return to `dos_n`=`lot_n`=1 and `fault_kind`=0 at the third clock edge after `clr_async` is first sampled high. A level held high or a falling edge clears nothing.
- R6: A `dos_req` cycle drives only `dos_n` low. A `lot_req` cycle drives only `lot_n` low.
- R7: `fault_kind` encodes 0 none, 1 tracking loss, 2 degradation, 3 loss of signal. It holds the highest class set since the last clear and never moves down except on a clear.
- R8: A clear and a set in the same cycle leave the outputs cleared. A fault that is still present sets the latches again at the next sample that shows it.
- R9: After reset, `dos_n`=1, `lot_n`=1, `fault_kind`=0, `mon`=0 and `mon_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | New demodulated sample pair present |
| sin_in | input | 16 | Signed demodulated sine sample |
| cos_in | input | 16 | Signed demodulated cosine sample |
| sin_phi | input | 16 | Signed sine of tracked angle, Q1.15 |
| cos_phi | input | 16 | Signed cosine of tracked angle, Q1.15 |
| dos_req | input | 1 | Degradation set request from an external detector |
| lot_req | input | 1 | Tracking-loss set request from an external detector |
| clr_async | input | 1 | Asynchronous clear strobe, acts on its rising edge |
| mon | output | 16 | Signed monitor value |
| mon_valid | output | 1 | `mon` updated this cycle |
| dos_n | output | 1 | Degradation fault, active low |
| lot_n | output | 1 | Tracking-loss fault, active low |
| fault_kind | output | 2 | Highest latched fault class |

## Verification
Assertions check on every cycle that a low monitor forces both outputs low, that the latches hold, that the fault class never moves down, that a clear pulse empties every latch, and that the valid strobe is delayed by one cycle. The arithmetic of the monitor is checked only by the bench's scenarios. Those scenarios cover saturation, tracking at a constant amplitude over a sweep of angles, the swing between mismatched amplitudes, and the three-cycle clear latency. They also cover a clear that collides with a set, and the fault setting again after it is cleared.

// File: rtl/rsv_mon_pkg.sv
// Shared types for the resolver monitor.
// Assumes fault classes are ordered so that a larger code is more severe.
package rsv_mon_pkg;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_LOT  = 2'd1,
        FK_DOS  = 2'd2,
        FK_LOS  = 2'd3
    } fault_kind_t;

    // Returns the more severe of two fault classes.
    function automatic fault_kind_t fk_max(input fault_kind_t a, input fault_kind_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rsv_edge_sync.sv
// Synchroniser chain followed by a rising-edge detector.
// Assumes din is asynchronous to clk. rise is a one-cycle pulse taken from
// the last synchroniser stage.
module rsv_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        genvar g;
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                // Later stages: shift the value along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;

    // R5: the edge pulse never lasts two cycles.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/rsv_mon_calc.sv
// Forms the monitor value sin_in*sin_phi + cos_in*cos_phi at full width.
// The sum is shifted right by DW-1 (the angle terms are Q1.DW-1) and either
// saturated or wrapped to MW bits, then registered together with a valid flag.
module rsv_mon_calc #(
    parameter int DW       = 16,
    parameter int MW       = 16,
    parameter bit SATURATE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] sin_in,
    input  logic signed [DW-1:0] cos_in,
    input  logic signed [DW-1:0] sin_phi,
    input  logic signed [DW-1:0] cos_phi,
    output logic signed [MW-1:0] mon,
    output logic                 mon_valid
);
    localparam int PW = 2 * DW;
    localparam int SW = PW + 1;
    localparam int SH = DW - 1;
    localparam logic signed [SW-1:0] HI = SW'((2 ** (MW - 1)) - 1);
    localparam logic signed [SW-1:0] LO = ~HI;

    logic signed [PW-1:0] p_sin;
    logic signed [PW-1:0] p_cos;
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] scaled;
    logic signed [MW-1:0] narrowed;

    // Full-width products and their sum, with no loss of precision.
    always_comb begin
        p_sin  = sin_in * sin_phi;
        p_cos  = cos_in * cos_phi;
        sum    = SW'(p_sin) + SW'(p_cos);
        scaled = sum >>> SH;
    end

    generate
        if (SATURATE) begin : g_sat
            // Clamp values outside the output range to its limits.
            always_comb begin
                if (scaled > HI)      narrowed = HI[MW-1:0];
                else if (scaled < LO) narrowed = LO[MW-1:0];
                else                  narrowed = scaled[MW-1:0];
            end
        end else begin : g_wrap
            // Keep the low bits only.
            always_comb narrowed = scaled[MW-1:0];
        end
    endgenerate

    // Register the monitor value when a sample arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon       <= '0;
            mon_valid <= 1'b0;
        end else begin
            mon_valid <= smp_valid;
            if (smp_valid) mon <= narrowed;
        end
    end

    // R1: the valid flag follows the sample strobe by exactly one cycle.
    a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> mon_valid);
    a_r1_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !mon_valid);
    // R1: without a sample the monitor value does not change.
    a_r1_mon_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(mon));

endmodule

// File: rtl/rsv_fault_latch.sv
// Active-low fault latches with a severity class.
// Assumes clr is a single-cycle pulse and that a clear takes priority over
// any set in the same cycle.
module rsv_fault_latch
    import rsv_mon_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        los_evt,
    input  logic        dos_req,
    input  logic        lot_req,
    input  logic        clr,
    output logic        dos_n,
    output logic        lot_n,
    output fault_kind_t kind
);
    fault_kind_t incoming;

    // Most severe class requested this cycle.
    always_comb begin
        if (los_evt)      incoming = FK_LOS;
        else if (dos_req) incoming = FK_DOS;
        else if (lot_req) incoming = FK_LOT;
        else              incoming = FK_NONE;
    end

    // Set, hold and clear the latches and the class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dos_n <= 1'b1;
            lot_n <= 1'b1;
            kind  <= FK_NONE;
        end else if (clr) begin
            dos_n <= 1'b1;
            lot_n <= 1'b1;
            kind  <= FK_NONE;
        end else begin
            if (los_evt || dos_req) dos_n <= 1'b0;
            if (los_evt || lot_req) lot_n <= 1'b0;
            kind <= fk_max(kind, incoming);
        end
    end

    // R3: loss of signal drives both outputs low with the top class.
    a_r3_los_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
        (los_evt && !clr) |=> (!dos_n && !lot_n && kind == FK_LOS));
    // R4: a low output stays low until a clear.
    a_r4_dos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!dos_n && !clr) |=> !dos_n);
    a_r4_lot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!lot_n && !clr) |=> !lot_n);
    // R7: the class never moves down without a clear.
    a_r7_no_downgrade: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> kind >= $past(kind));
    // R8: a clear wins over a set in the same cycle.
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (dos_n && lot_n && kind == FK_NONE));
    // R6: a degradation request alone sets only its own output.
    a_r6_dos_only: assert property (@(posedge clk) disable iff (!rst_n)
        (dos_req && !los_evt && !lot_req && !clr && lot_n) |=> (!dos_n && lot_n));

endmodule

// File: rtl/rsv_mon_top.sv
// Resolver monitor and loss-of-signal detector.
// Assumes the angle terms are Q1.15 and that smp_valid marks one new sample
// pair per strobe. clr_async may come from any clock domain.
module rsv_mon_top
    import rsv_mon_pkg::*;
#(
    parameter int DW                  = 16,
    parameter int MW                  = 16,
    parameter int SYNC_STAGES         = 2,
    parameter logic signed [15:0] THRESH = 16'sd3277
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] sin_in,
    input  logic signed [DW-1:0] cos_in,
    input  logic signed [DW-1:0] sin_phi,
    input  logic signed [DW-1:0] cos_phi,
    input  logic                 dos_req,
    input  logic                 lot_req,
    input  logic                 clr_async,
    output logic signed [MW-1:0] mon,
    output logic                 mon_valid,
    output logic                 dos_n,
    output logic                 lot_n,
    output logic [1:0]           fault_kind
);
    localparam logic signed [MW-1:0] THR = MW'(THRESH);

    logic        clr_pulse;
    logic        los_evt;
    fault_kind_t kind;

    rsv_mon_calc #(.DW(DW), .MW(MW), .SATURATE(1'b1)) u_calc (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .sin_in    (sin_in),
        .cos_in    (cos_in),
        .sin_phi   (sin_phi),
        .cos_phi   (cos_phi),
        .mon       (mon),
        .mon_valid (mon_valid)
    );

    rsv_edge_sync #(.STAGES(SYNC_STAGES)) u_clr (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (clr_async),
        .rise  (clr_pulse)
    );

    // A fresh monitor value below the minimum is a loss of signal.
    always_comb los_evt = mon_valid && (mon < THR);

    rsv_fault_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .los_evt (los_evt),
        .dos_req (dos_req),
        .lot_req (lot_req),
        .clr     (clr_pulse),
        .dos_n   (dos_n),
        .lot_n   (lot_n),
        .kind    (kind)
    );

    assign fault_kind = kind;

    // R3: the top class always means both outputs are low.
    a_r3_class_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_kind == 2'd3) |-> (!dos_n && !lot_n));

endmodule

// File: tb/tb_rsv_mon_top.sv
module tb_rsv_mon_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [15:0] sin_in = '0, cos_in = '0, sin_phi = '0, cos_phi = '0;
    logic dos_req = 1'b0, lot_req = 1'b0, clr_async = 1'b0;
    logic signed [15:0] mon;
    logic mon_valid, dos_n, lot_n;
    logic [1:0] fault_kind;

    int n_chk = 0;
    int n_fail = 0;
    int e_dos, e_lot, e_kind;
    bit done = 1'b0;

    localparam int THR = 3277;

    rsv_mon_top dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .sin_in(sin_in), .cos_in(cos_in), .sin_phi(sin_phi), .cos_phi(cos_phi),
        .dos_req(dos_req), .lot_req(lot_req), .clr_async(clr_async),
        .mon(mon), .mon_valid(mon_valid), .dos_n(dos_n), .lot_n(lot_n),
        .fault_kind(fault_kind)
    );

    always #4 clk = ~clk;

    function automatic int exp_mon(int s, int c, int sp, int cp);
        longint t;
        t = longint'(s) * sp + longint'(c) * cp;
        t = t >>> 15;
        if (t > 32767) t = 32767;
        if (t < -32768) t = -32768;
        return int'(t);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_latches(input string tag);
        chk(dos_n == e_dos[0], {tag, " dos_n"}, int'(dos_n), e_dos);
        chk(lot_n == e_lot[0], {tag, " lot_n"}, int'(lot_n), e_lot);
        chk(int'(fault_kind) == e_kind, {tag, " kind"}, int'(fault_kind), e_kind);
    endtask

    task automatic model_clear();
        e_dos = 1; e_lot = 1; e_kind = 0;
    endtask

    task automatic model_set(input int k);
        if (k == 3) begin e_dos = 0; e_lot = 0; end
        if (k == 2) e_dos = 0;
        if (k == 1) e_lot = 0;
        if (k > e_kind) e_kind = k;
    endtask

    // Full clear: R5 latency of three edges from the first high sample.
    task automatic do_clear();
        clr_async = 1'b1;
        tick(); tick();
        tick();
        model_clear();
        check_latches("R5 clear");
        clr_async = 1'b0;
        tick(); tick();
    endtask

    task automatic apply(input int s, input int c, input int sp, input int cp);
        sin_in = 16'(s); cos_in = 16'(c); sin_phi = 16'(sp); cos_phi = 16'(cp);
        smp_valid = 1'b1;
        tick();
        smp_valid = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        // R9: reset state
        model_clear();
        check_latches("R9 reset");
        chk(mon == 0, "R9 mon", int'(mon), 0);
        chk(mon_valid == 0, "R9 mon_valid", int'(mon_valid), 0);

        // R1 and R3: small monitor value, then loss of signal
        apply(100, 0, 32767, 0);
        chk(mon_valid == 1, "R1 valid", int'(mon_valid), 1);
        chk(int'(mon) == exp_mon(100, 0, 32767, 0), "R1 mon small", int'(mon), exp_mon(100, 0, 32767, 0));
        chk(dos_n == 1, "R3 not before second edge", int'(dos_n), 1);
        tick();
        chk(mon_valid == 0, "R1 valid drop", int'(mon_valid), 0);
        model_set(3);
        check_latches("R3 los");

        // R4: healthy sample does not release the latches
        apply(0, 20000, 0, 32767);
        tick(); tick();
        check_latches("R4 hold");
        do_clear();

        // R1: saturation at the top of the range
        apply(-32768, -32768, -32768, -32768);
        chk(mon == 16'sd32767, "R1 saturate", int'(mon), 32767);
        tick();
        check_latches("R1 no los on saturated");

        // R2: matched amplitudes tracking over a sweep of angles
        for (int a = 0; a < 360; a += 15) begin
            real th;
            int s, c, sp, cp;
            th = a * 3.14159265358979 / 180.0;
            s = $rtoi($floor(20000.0 * $sin(th) + 0.5));
            c = $rtoi($floor(20000.0 * $cos(th) + 0.5));
            sp = $rtoi($floor(32767.0 * $sin(th) + 0.5));
            cp = $rtoi($floor(32767.0 * $cos(th) + 0.5));
            apply(s, c, sp, cp);
            chk((int'(mon) >= 19997) && (int'(mon) <= 20003), "R2 matched", int'(mon), 20000);
        end
        // R2: mismatched amplitudes swing between them
        apply(0, 12000, 0, 32767);
        chk((int'(mon) >= 11997) && (int'(mon) <= 12003), "R2 mismatch 0deg", int'(mon), 12000);
        apply(20000, 0, 32767, 0);
        chk((int'(mon) >= 19997) && (int'(mon) <= 20003), "R2 mismatch 90deg", int'(mon), 20000);
        tick();
        check_latches("R2 no fault");

        // R6 and R7: degradation only, then tracking loss does not lower the class
        dos_req = 1'b1; tick(); dos_req = 1'b0;
        model_set(2);
        check_latches("R6 dos only");
        lot_req = 1'b1; tick(); lot_req = 1'b0;
        model_set(1);
        check_latches("R7 keeps dos class");
        do_clear();
        lot_req = 1'b1; tick(); lot_req = 1'b0;
        model_set(1);
        check_latches("R6 lot only");
        // R7: loss of signal raises the class above tracking loss
        apply(0, 0, 32767, 32767);
        tick();
        model_set(3);
        check_latches("R7 raise to los");

        // R5: a held level and a falling edge clear nothing
        do_clear();
        clr_async = 1'b1;
        tick(); tick(); tick();
        dos_req = 1'b1; tick(); dos_req = 1'b0;
        tick(); tick(); tick();
        model_set(2);
        check_latches("R5 held level");
        clr_async = 1'b0;
        tick(); tick(); tick(); tick();
        check_latches("R5 falling edge");
        do_clear();

        // R8: a clear and a set in the same cycle leave the outputs cleared
        lot_req = 1'b1; tick(); lot_req = 1'b0;
        model_set(1);
        clr_async = 1'b1;
        tick(); tick();
        dos_req = 1'b1;
        tick();
        dos_req = 1'b0;
        model_clear();
        check_latches("R8 clear wins");
        clr_async = 1'b0;
        tick(); tick();
        // R8: a fault still present sets again on the next sample
        apply(50, 50, 32767, 32767);
        tick();
        model_set(3);
        check_latches("R8 sets again");
        do_clear();

        // Random stimulus against the bench model
        for (int i = 0; i < 400; i++) begin
            int s, c, sp, cp, em, rq;
            s  = int'($signed(16'($urandom)));
            c  = int'($signed(16'($urandom)));
            sp = int'($signed(16'($urandom)));
            cp = int'($signed(16'($urandom)));
            rq = int'($urandom % 8);
            em = exp_mon(s, c, sp, cp);
            dos_req = (rq == 1);
            lot_req = (rq == 2);
            apply(s, c, sp, cp);
            dos_req = 1'b0; lot_req = 1'b0;
            chk(int'(mon) == em, "R1 random mon", int'(mon), em);
            if (rq == 1) model_set(2);
            if (rq == 2) model_set(1);
            tick();
            if (em < THR) model_set(3);
            check_latches("R3 random");
            if ((i % 16) == 15) do_clear();
        end

        finish_up();
    end
endmodule